// File: doc/BRIEF.md
# PWM Timer with Trigger-Forced Compare

This block is an up-counting timer driving one PWM channel. A prescaler divides the clock, and the counter runs from zero up to an auto-reload value before it wraps. The channel keeps an internal reference level. That level is active while the counter sits below the compare value and inactive otherwise. The main and complementary pins each take the reference through their own polarity bit. When the counter is stopped, both pins can be parked at programmed idle levels.

Several internal trigger sources feed a selector. When fast-compare is enabled, a rising edge on the selected source forces a compare match, and the reference drops to inactive on the next clock. This happens whether or not the counter is running, and there is no separate slave mode that gates it. A connected timer's trigger output can therefore disturb this channel's pins even when no link between the two was intended.

A small master section drives a trigger output. In one mode it pulses only on a software update-generate strobe. In the other mode it pulses on every update event.

Top module: `pwm_trig_timer`

## Requirements
- R1: After reset, with all configuration inputs at zero, out_main, out_comp and trgo are all 0.
- R2: While cnt_en is 1, the counter advances once every cfg_psc+1 clocks and wraps from the active reload value to 0. One period is (reload+1)*(psc+1) clocks. The reference is 1 exactly while counter < active compare value, so one period holds min(compare, reload+1)*(psc+1) reference-high clocks.
- R3: A one-cycle sw_ug clears the counter and the prescaler on the next clock, loads psc, reload and compare from the cfg inputs, and re-evaluates the reference at counter value 0. This also works while cnt_en is 0.
- R4: Changes to cfg_ccr, cfg_arr and cfg_psc have no effect until the next update event, which is either a wrap or sw_ug.
- R5: Only trig_src[cfg_trig_sel] is observed. It is registered, and only a 0-to-1 change counts as an edge. A source that stays high, or an unselected source that rises, produces no edge.
- R6: With cfg_fast=1, a trigger edge drives the reference to 0 on the next clock, even while cnt_en is 0. The reference stays 0 until the counter value next changes or sw_ug is applied.
- R7: With cfg_fast=0, trigger edges leave the reference unchanged.
- R8: If a forced match and sw_ug fall in the same cycle, the forced match wins and the reference becomes 0.
- R9: Outside the parked state, out_main = reference XOR cfg_pol_main and out_comp = reference XOR cfg_pol_comp.
- R10: When cnt_en=0 and cfg_offstate=1, out_main equals cfg_idle_main and out_comp equals cfg_idle_comp. When cfg_offstate=0, the pins follow R9.
- R11: With cfg_master=0, trgo is high for exactly the one clock after each cycle in which sw_ug is high. With cfg_master=1, trgo is high for the one clock after every update event (wrap or sw_ug).
- R12: The counter never exceeds the active reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_psc | input | PSC_W | Prescaler divide minus one (preloaded) |
| cfg_arr | input | CNT_W | Auto-reload value (preloaded) |
| cfg_ccr | input | CNT_W | Compare value (preloaded) |
| cfg_fast | input | 1 | Fast-compare enable: trigger edge forces a match |
| cfg_trig_sel | input | SEL_W | Index of the observed trigger source |
| cfg_master | input | 1 | Trigger output source: 0 = sw_ug only, 1 = any update |
| cfg_pol_main | input | 1 | Main pin polarity (1 inverts) |
| cfg_pol_comp | input | 1 | Complementary pin polarity (1 inverts) |
| cfg_idle_main | input | 1 | Main pin level when parked |
| cfg_idle_comp | input | 1 | Complementary pin level when parked |
| cfg_offstate | input | 1 | Park pins at idle levels while the counter is stopped |
| cnt_en | input | 1 | Counter enable |
| sw_ug | input | 1 | Software update-generate strobe |
| trig_src | input | N_TRIG | Internal trigger sources |
| out_main | output | 1 | Main channel output |
| out_comp | output | 1 | Complementary channel output |
| trgo | output | 1 | Trigger output pulse |

## Verification
A corrupted prescaler or counter shows up within one PWM period as a wrong count of high clocks on out_main, or as a trgo pulse arriving at the wrong place. A missing preload shows up one period earlier than it should. A mis-registered trigger edge or a broken fast-compare gate shows up on the pins in the very next clock after the source rises. The same holds for a wrong priority between the strobe and the forced match, and the bench therefore samples at that cycle while the counter is stopped.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic {
    MM_STROBE_ONLY = 1'b0,
    MM_ANY_UPDATE  = 1'b1
  } pwmt_master_e;

  // PWM mode 1 level: active while the count is below the compare value
  function automatic logic pwm1_active(input logic [31:0] count, input logic [31:0] cmp);
    return count < cmp;
  endfunction

  // pin level: parked -> idle value, otherwise reference through polarity
  function automatic logic pin_level(input logic refl, input logic pol,
                                     input logic park, input logic idle);
    return park ? idle : (refl ^ pol);
  endfunction

endpackage

// File: rtl/pwmt_count.sv
module pwmt_count #(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PSC_W-1:0] cfg_psc,
  input  logic [CNT_W-1:0] cfg_arr,
  input  logic [CNT_W-1:0] cfg_ccr,
  input  logic             cnt_en,
  input  logic             sw_ug,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic [CNT_W-1:0] ccr_nxt,
  output logic [CNT_W-1:0] arr_act,
  output logic             cnt_load,
  output logic             upd_evt
);
  logic [PSC_W-1:0] psc_q, psc_act;
  logic [CNT_W-1:0] ccr_act;
  logic             tick, wrap;

  assign tick     = cnt_en && (psc_q == psc_act);
  assign wrap     = tick && (cnt_q == arr_act);
  assign upd_evt  = sw_ug || wrap;
  assign cnt_load = sw_ug || tick;
  assign ccr_nxt  = upd_evt ? cfg_ccr : ccr_act;

  always_comb begin
    if (upd_evt)   cnt_nxt = '0;
    else if (tick) cnt_nxt = cnt_q + 1'b1;
    else           cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q   <= '0;
      cnt_q   <= '0;
      psc_act <= '0;
      arr_act <= '0;
      ccr_act <= '0;
    end else begin
      cnt_q <= cnt_nxt;
      if (sw_ug || tick)  psc_q <= '0;
      else if (cnt_en)    psc_q <= psc_q + 1'b1;
      if (upd_evt) begin
        psc_act <= cfg_psc;
        arr_act <= cfg_arr;
        ccr_act <= cfg_ccr;
      end
    end
  end
endmodule

// File: rtl/pwmt_trig.sv
module pwmt_trig #(
  parameter int N_TRIG = 4,
  localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_TRIG-1:0] trig_src,
  input  logic [SEL_W-1:0]  trig_sel,
  output logic              trig_edge
);
  logic sel_now, sel_q;

  always_comb begin
    sel_now = 1'b0;
    for (int i = 0; i < N_TRIG; i++)
      if (trig_sel == SEL_W'(i)) sel_now = trig_src[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sel_q <= 1'b0;
    else        sel_q <= sel_now;
  end

  assign trig_edge = sel_now && !sel_q;
endmodule

// File: rtl/pwmt_oc.sv
module pwmt_oc #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_fast,
  input  logic             trig_edge,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] ccr_nxt,
  output logic             force_match,
  output logic             ref_q
);
  assign force_match = cfg_fast && trig_edge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ref_q <= 1'b0;
    else if (force_match) ref_q <= 1'b0;
    else if (cnt_load)    ref_q <= pwmt_pkg::pwm1_active(32'(cnt_nxt), 32'(ccr_nxt));
  end
endmodule

// File: rtl/pwm_trig_timer.sv
module pwm_trig_timer #(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int N_TRIG = 4,
  localparam int SEL_W = (N_TRIG > 1) ? $clog2(N_TRIG) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PSC_W-1:0]  cfg_psc,
  input  logic [CNT_W-1:0]  cfg_arr,
  input  logic [CNT_W-1:0]  cfg_ccr,
  input  logic              cfg_fast,
  input  logic [SEL_W-1:0]  cfg_trig_sel,
  input  logic              cfg_master,
  input  logic              cfg_pol_main,
  input  logic              cfg_pol_comp,
  input  logic              cfg_idle_main,
  input  logic              cfg_idle_comp,
  input  logic              cfg_offstate,
  input  logic              cnt_en,
  input  logic              sw_ug,
  input  logic [N_TRIG-1:0] trig_src,
  output logic              out_main,
  output logic              out_comp,
  output logic              trgo
);
  localparam int N_PIN = 2;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, ccr_nxt, arr_act;
  logic             cnt_load, upd_evt, trig_edge, force_match, ref_q, park;
  logic             trgo_q;
  logic [N_PIN-1:0] pol_v, idle_v, pin_v;
  pwmt_pkg::pwmt_master_e master_mode;

  pwmt_count #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_count (
    .clk(clk), .rst_n(rst_n), .cfg_psc(cfg_psc), .cfg_arr(cfg_arr),
    .cfg_ccr(cfg_ccr), .cnt_en(cnt_en), .sw_ug(sw_ug), .cnt_q(cnt_q),
    .cnt_nxt(cnt_nxt), .ccr_nxt(ccr_nxt), .arr_act(arr_act),
    .cnt_load(cnt_load), .upd_evt(upd_evt)
  );

  pwmt_trig #(.N_TRIG(N_TRIG)) u_trig (
    .clk(clk), .rst_n(rst_n), .trig_src(trig_src),
    .trig_sel(cfg_trig_sel), .trig_edge(trig_edge)
  );

  pwmt_oc #(.CNT_W(CNT_W)) u_oc (
    .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .trig_edge(trig_edge),
    .cnt_load(cnt_load), .cnt_nxt(cnt_nxt), .ccr_nxt(ccr_nxt),
    .force_match(force_match), .ref_q(ref_q)
  );

  assign park   = !cnt_en && cfg_offstate;
  assign pol_v  = {cfg_pol_comp, cfg_pol_main};
  assign idle_v = {cfg_idle_comp, cfg_idle_main};

  for (genvar g = 0; g < N_PIN; g++) begin : g_pin
    assign pin_v[g] = pwmt_pkg::pin_level(ref_q, pol_v[g], park, idle_v[g]);
  end

  assign out_main = pin_v[0];
  assign out_comp = pin_v[1];

  assign master_mode = pwmt_pkg::pwmt_master_e'(cfg_master);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trgo_q <= 1'b0;
    else        trgo_q <= (master_mode == pwmt_pkg::MM_ANY_UPDATE) ? upd_evt : sw_ug;
  end
  assign trgo = trgo_q;
endmodule

// File: rtl/pwm_trig_timer_chk.sv
module pwm_trig_timer_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_fast,
  input logic             cfg_master,
  input logic             cfg_offstate,
  input logic             cfg_idle_main,
  input logic             cfg_idle_comp,
  input logic             cnt_en,
  input logic             sw_ug,
  input logic             trig_edge,
  input logic             cnt_load,
  input logic             ref_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic [CNT_W-1:0] arr_act,
  input logic             out_main,
  input logic             out_comp,
  input logic             trgo
);
  // R6
  force_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_fast && trig_edge) |=> !ref_q);

  // R7
  no_fast_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_fast && !cnt_load) |=> $stable(ref_q));

  // R3
  ug_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_ug |=> (cnt_q == '0));

  // R2
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !sw_ug) |=> $stable(cnt_q));

  // R12
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= arr_act);

  // R11
  trgo_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |=> (trgo == $past(sw_ug)));

  // R10
  park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && cfg_offstate) |-> (out_main == cfg_idle_main && out_comp == cfg_idle_comp));
endmodule

bind pwm_trig_timer pwm_trig_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_fast(cfg_fast), .cfg_master(cfg_master),
  .cfg_offstate(cfg_offstate), .cfg_idle_main(cfg_idle_main),
  .cfg_idle_comp(cfg_idle_comp), .cnt_en(cnt_en), .sw_ug(sw_ug),
  .trig_edge(trig_edge), .cnt_load(cnt_load), .ref_q(ref_q), .cnt_q(cnt_q),
  .arr_act(arr_act), .out_main(out_main), .out_comp(out_comp), .trgo(trgo)
);

// File: tb/pwm_trig_timer_test.sv
module pwm_trig_timer_test;
  localparam int CNT_W = 16, PSC_W = 16, N_TRIG = 4, SEL_W = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [PSC_W-1:0] cfg_psc = '0;
  logic [CNT_W-1:0] cfg_arr = '0, cfg_ccr = '0;
  logic cfg_fast = 0, cfg_master = 0, cfg_pol_main = 0, cfg_pol_comp = 0;
  logic cfg_idle_main = 0, cfg_idle_comp = 0, cfg_offstate = 0, cnt_en = 0, sw_ug = 0;
  logic [SEL_W-1:0] cfg_trig_sel = '0;
  logic [N_TRIG-1:0] trig_src = '0;
  logic out_main, out_comp, trgo;

  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  pwm_trig_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .N_TRIG(N_TRIG)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_psc(cfg_psc), .cfg_arr(cfg_arr), .cfg_ccr(cfg_ccr),
    .cfg_fast(cfg_fast), .cfg_trig_sel(cfg_trig_sel), .cfg_master(cfg_master),
    .cfg_pol_main(cfg_pol_main), .cfg_pol_comp(cfg_pol_comp),
    .cfg_idle_main(cfg_idle_main), .cfg_idle_comp(cfg_idle_comp),
    .cfg_offstate(cfg_offstate), .cnt_en(cnt_en), .sw_ug(sw_ug),
    .trig_src(trig_src), .out_main(out_main), .out_comp(out_comp), .trgo(trgo)
  );

  // PWM vectors: prescaler, reload, compare
  localparam int NV = 5;
  localparam int V_PSC [NV] = '{0, 1, 3, 0, 2};
  localparam int V_ARR [NV] = '{9, 5, 4, 7, 3};
  localparam int V_CCR [NV] = '{4, 3, 0, 8, 2};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_ug();
    @(negedge clk); sw_ug = 1'b1;
    @(negedge clk); sw_ug = 1'b0;
  endtask

  task automatic run_window(input int n, output int hi, output int tg);
    hi = 0; tg = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(out_main);
      tg += int'(trgo);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, tg, exp_hi, per;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 out_main", out_main, 0);
    check("R1 out_comp", out_comp, 0);
    check("R1 trgo", trgo, 0);

    // R2, R11 vector table, master on any update
    cfg_master = 1'b1;
    for (int v = 0; v < NV; v++) begin
      cfg_psc = PSC_W'(V_PSC[v]);
      cfg_arr = CNT_W'(V_ARR[v]);
      cfg_ccr = CNT_W'(V_CCR[v]);
      cnt_en  = 1'b1;
      pulse_ug();
      per    = (V_ARR[v] + 1) * (V_PSC[v] + 1);
      exp_hi = 2 * ((V_CCR[v] < V_ARR[v] + 1) ? V_CCR[v] : V_ARR[v] + 1) * (V_PSC[v] + 1);
      run_window(2 * per, hi, tg);
      check("R2 high clocks", hi, exp_hi);
      check("R11 update pulses", tg, 2);
    end

    // R4 preload: compare and reload changed right after the strobe
    cfg_psc = '0; cfg_arr = 16'd9; cfg_ccr = 16'd2; cnt_en = 1'b1;
    pulse_ug();
    cfg_ccr = 16'd7; cfg_arr = 16'd4;
    run_window(5, hi, tg);
    check("R4 old compare first half", hi, 2);
    run_window(5, hi, tg);
    check("R4 old reload no early wrap", tg, 0);
    run_window(5, hi, tg);
    check("R4 new compare after update", hi, 5);
    check("R4 wrap pulse at old period", tg, 1);
    run_window(5, hi, tg);
    check("R4 new reload period", tg, 1);

    // R11 strobe-only master: wraps do not pulse
    cfg_master = 1'b0; cfg_arr = 16'd4; cfg_ccr = 16'd2;
    pulse_ug();
    run_window(15, hi, tg);
    check("R11 strobe only pulses", tg, 1);

    // R6 forced match with the counter stopped
    cnt_en = 1'b0; cfg_arr = 16'd9; cfg_ccr = 16'd5;
    cfg_fast = 1'b1; cfg_trig_sel = 2'd0; cfg_pol_comp = 1'b1;
    pulse_ug();
    check("R3 reference at zero", out_main, 1);
    check("R9 comp inverted", out_comp, 0);
    trig_src[0] = 1'b1;
    @(negedge clk);
    check("R6 forced inactive", out_main, 0);
    check("R9 comp rises on force", out_comp, 1);
    @(negedge clk);
    check("R6 stays inactive", out_main, 0);
    trig_src[0] = 1'b0;
    @(negedge clk);

    // R7 fast compare off: edge ignored
    cfg_fast = 1'b0;
    pulse_ug();
    trig_src[0] = 1'b1;
    @(negedge clk);
    check("R7 edge ignored", out_main, 1);
    trig_src[0] = 1'b0;
    @(negedge clk);

    // R5 unselected source ignored, then selected
    cfg_fast = 1'b1;
    trig_src[2] = 1'b1;
    @(negedge clk);
    check("R5 unselected ignored", out_main, 1);
    trig_src[2] = 1'b0;
    @(negedge clk);
    cfg_trig_sel = 2'd2;
    @(negedge clk);
    trig_src[2] = 1'b1;
    @(negedge clk);
    check("R5 selected source forces", out_main, 0);
    trig_src[2] = 1'b0; cfg_trig_sel = 2'd0;
    @(negedge clk);

    // R8 forced match beats strobe
    sw_ug = 1'b1; trig_src[0] = 1'b1;
    @(negedge clk);
    sw_ug = 1'b0;
    check("R8 force wins over strobe", out_main, 0);
    trig_src[0] = 1'b0;
    @(negedge clk);

    // R10 parking while stopped
    cfg_offstate = 1'b1; cfg_idle_main = 1'b1; cfg_idle_comp = 1'b0;
    @(negedge clk);
    check("R10 main idle", out_main, 1);
    check("R10 comp idle", out_comp, 0);
    cfg_offstate = 1'b0;
    @(negedge clk);
    check("R10 main follows reference", out_main, 0);
    check("R10 comp follows reference", out_comp, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule